// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block controls one port of eight general-purpose pins. Software reaches it through a plain memory-mapped register interface, with a write strobe, a read strobe, a byte address and 32-bit data in each direction. For each pin the block stores four things: a mode bit that hands the pin to GPIO use, a direction bit, an output level and interrupt settings. It also samples the pin inputs through a synchronizer.

Every writable register has two addresses. A direct write replaces the whole register. A masked write changes only the pins selected by a mask byte, so separate software threads can update different pins without a read-modify-write.

The same synchronized samples feed an interrupt detector. Each pin can be set to rising-edge, falling-edge, both-edge, level-high or level-low detection. A status bit is set for each pin that sees its condition. The status bits are ANDed with per-pin enables and ORed together onto one interrupt output.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Reset behaviour. While `rstN` is low, every stored register clears to zero and the synchronizer flops clear to zero. After reset, `pinOe`, `pinOut` and `irq` are all 0, so every interrupt is disabled.
- R2: Direct register map. Registers sit at 16-byte offsets: mode 0x00, direction 0x10, drive 0x20, sample 0x30, status 0x40, enable 0x50, trigger 0x60 and acknowledge 0x70. Each 8-bit register uses data bits 7:0, and the trigger register uses bits 23:0. Writes to the sample register are ignored. The acknowledge register reads as 0. Reads return 0 at an unaligned or unused address, and `rdData` is 0 while `rdEn` is low.
- R3: Masked aliases. Setting address bit 7 gives a masked alias of the mode, direction, drive, status and enable registers (0x80, 0x90, 0xA0, 0xC0, 0xD0). In a masked write, bit 8+n selects pin n and bit n gives its new value. Pins whose mask bit is 0 keep their value. A read of an alias returns the register itself. There is no alias for the sample or acknowledge register, and reads of those alias addresses return 0.
- R4: The masked trigger alias (0xE0) applies the mask byte and value byte to the polarity bits 7:0 only. It leaves bits 23:8 unchanged.
- R5: `pinOut` equals the drive register. Bit n of `pinOe` is 1 only when both mode bit n and direction bit n are 1.
- R6: The sample register returns the pin inputs through a two-flop synchronizer. An input change made between clock edges becomes readable after the second rising edge that follows it.
- R7: Trigger bits for pin n: bit n is the polarity (1 = high or rising), bit 8+n selects edge detection, and bit 16+n adds the opposite edge. This gives the codes rising 0x000101, falling 0x000100, both 0x010100, level-high 0x000001 and level-low 0x000000, each shifted left by n. Edge detection compares the current synchronized sample with the one before it. An edge-type status bit is set on the third rising edge after the input change, and it stays set until it is cleared.
- R8: A level-type status bit follows the active level on every cycle. An acknowledge cannot clear it while the level is active, and it drops once the level goes inactive.
- R9: Writing 1 to acknowledge bit n clears the status of edge-type pin n, and writing 0 has no effect. A direct or masked write to the status register loads the bits of edge-type pins. An edge detected in the same cycle still sets its bit.
- R10: `irq` is 1 exactly when some pin has both its status bit and its enable bit set. It follows a register change on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte address; bit 7 selects the masked alias |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` while `rdEn` is high |
| pinIn | input | 8 | Asynchronous pin inputs |
| pinOut | output | 8 | Pin output levels |
| pinOe | output | 8 | Per-pin output-driver enables |
| irq | output | 1 | Port interrupt |

## Verification
The assertions assume that each access uses a 16-byte-aligned address and that `wrEn` and `addr` stay steady across the clock edge that takes the write. The bench keeps to this by driving all strobes, addresses and data at the falling edge and holding a write for exactly one rising edge. It also changes `pinIn` only at a falling edge and then waits at least four cycles before it reads status. This makes sure each pin change passes through the synchronizer and the edge stage before any expected value is compared.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PIN_CNT = 8;
  localparam int LVL_W   = 3 * PIN_CNT;
  localparam int REG_CNT = 8;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int ADDR_W  = IDX_W + 5;
  localparam int DATA_W  = 32;

  // Register index = address bits 6:4; the decode depends on this order.
  typedef enum logic [IDX_W-1:0] {
    RG_MODE = 3'd0,
    RG_DIR  = 3'd1,
    RG_DRV  = 3'd2,
    RG_SAMP = 3'd3,
    RG_STAT = 3'd4,
    RG_ENAB = 3'd5,
    RG_TRIG = 3'd6,
    RG_ACK  = 3'd7
  } regIdx_e;

  typedef struct packed {
    logic [REG_CNT-1:0] wrHit;
    logic               masked;
    logic [REG_CNT-1:0] rdHit;
  } ctlStrobe_t;
endpackage

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
  import gpio_port_pkg::*;
(
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobe_t        strobe
);
  logic              aligned;
  logic              masked;
  logic [IDX_W-1:0]  idx;
  logic              noAlias;

  assign aligned = (addr[3:0] == 4'h0);
  assign masked  = addr[ADDR_W-1];
  assign idx     = addr[ADDR_W-2:4];
  assign noAlias = masked && ((idx == RG_SAMP) || (idx == RG_ACK));

  always_comb begin
    strobe        = '0;
    strobe.masked = masked;
    if (aligned && !noAlias) begin
      if (wrEn) strobe.wrHit[idx] = 1'b1;
      if (rdEn) strobe.rdHit[idx] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [DATA_W-1:0] rdData,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe,
  output logic              irq
);
  logic [PIN_CNT-1:0] modeQ, dirQ, drvQ, statQ, enabQ, prevQ;
  logic [LVL_W-1:0]   trigQ;
  logic [PIN_CNT-1:0] syncQ [SYNC_DEPTH];
  logic [PIN_CNT-1:0] syncd;
  logic [PIN_CNT-1:0] evt, lvlAct, edgeMode;
  logic [PIN_CNT-1:0] statBase, statD;

  function automatic logic [PIN_CNT-1:0] applyByte(
    input logic [PIN_CNT-1:0] old,
    input logic [DATA_W-1:0]  d,
    input logic               msk
  );
    logic [PIN_CNT-1:0] sel;
    sel = d[2*PIN_CNT-1:PIN_CNT];
    return msk ? ((old & ~sel) | (d[PIN_CNT-1:0] & sel)) : d[PIN_CNT-1:0];
  endfunction

  // input synchronizer chain
  genvar g;
  generate
    for (g = 0; g < SYNC_DEPTH; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[g] <= '0;
        else if (g == 0) syncQ[g] <= pinIn;
        else             syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign syncd = syncQ[SYNC_DEPTH-1];

  // per-pin condition detection
  generate
    for (g = 0; g < PIN_CNT; g++) begin : gPin
      logic rise, fall, polar, both;
      assign polar       = trigQ[g];
      assign edgeMode[g] = trigQ[g+PIN_CNT];
      assign both        = trigQ[g+2*PIN_CNT];
      assign rise        = syncd[g] & ~prevQ[g];
      assign fall        = ~syncd[g] & prevQ[g];
      assign evt[g]      = both ? (rise | fall) : (polar ? rise : fall);
      assign lvlAct[g]   = polar ? syncd[g] : ~syncd[g];
    end
  endgenerate

  always_comb begin
    statBase = strobe.wrHit[RG_STAT] ? applyByte(statQ, wrData, strobe.masked) : statQ;
    if (strobe.wrHit[RG_ACK]) statBase = statBase & ~wrData[PIN_CNT-1:0];
    statD = (edgeMode & (statBase | evt)) | (~edgeMode & lvlAct);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0; dirQ <= '0; drvQ <= '0; enabQ <= '0;
      statQ <= '0; prevQ <= '0; trigQ <= '0;
    end else begin
      prevQ <= syncd;
      statQ <= statD;
      if (strobe.wrHit[RG_MODE]) modeQ <= applyByte(modeQ, wrData, strobe.masked);
      if (strobe.wrHit[RG_DIR])  dirQ  <= applyByte(dirQ,  wrData, strobe.masked);
      if (strobe.wrHit[RG_DRV])  drvQ  <= applyByte(drvQ,  wrData, strobe.masked);
      if (strobe.wrHit[RG_ENAB]) enabQ <= applyByte(enabQ, wrData, strobe.masked);
      if (strobe.wrHit[RG_TRIG]) begin
        if (strobe.masked)
          trigQ[PIN_CNT-1:0] <= applyByte(trigQ[PIN_CNT-1:0], wrData, 1'b1);
        else
          trigQ <= wrData[LVL_W-1:0];
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdHit[RG_MODE]) rdData[PIN_CNT-1:0] = modeQ;
    if (strobe.rdHit[RG_DIR])  rdData[PIN_CNT-1:0] = dirQ;
    if (strobe.rdHit[RG_DRV])  rdData[PIN_CNT-1:0] = drvQ;
    if (strobe.rdHit[RG_SAMP]) rdData[PIN_CNT-1:0] = syncd;
    if (strobe.rdHit[RG_STAT]) rdData[PIN_CNT-1:0] = statQ;
    if (strobe.rdHit[RG_ENAB]) rdData[PIN_CNT-1:0] = enabQ;
    if (strobe.rdHit[RG_TRIG]) rdData[LVL_W-1:0]   = trigQ;
  end

  assign pinOut = drvQ;
  assign pinOe  = modeQ & dirQ;
  assign irq    = |(statQ & enabQ);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [PIN_CNT-1:0] pinIn,
  output logic [PIN_CNT-1:0] pinOut,
  output logic [PIN_CNT-1:0] pinOe,
  output logic               irq
);
  ctlStrobe_t strobe;

  gpio_port_ctl u_ctl (
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .strobe (strobe)
  );

  gpio_port_dp #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .pinIn  (pinIn),
    .rdData (rdData),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irq    (irq)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [DATA_W-1:0]  rdData,
  input logic [PIN_CNT-1:0] pinOut,
  input logic [PIN_CNT-1:0] pinOe,
  input logic               irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!irq && pinOe == '0 && pinOut == '0));

  // R2
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 8'h70) |-> (rdData == '0));

  // R3
  masked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'hA0 && wrData[15:8] == 8'h00) |=> $stable(pinOut));

  // R3
  masked_merge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'hA0) |=>
      (pinOut == (($past(pinOut) & ~$past(wrData[15:8])) |
                  ($past(wrData[7:0]) & $past(wrData[15:8])))));

  // R5
  mode_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h00 && wrData[7:0] == 8'h00) |=> (pinOe == '0));

  // R10
  enab_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 8'h50 && wrData[7:0] == 8'h00) |=> !irq);
endmodule

bind gpio_port_ctrl gpio_port_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .rdEn   (rdEn),
  .addr   (addr),
  .wrData (wrData),
  .rdData (rdData),
  .pinOut (pinOut),
  .pinOe  (pinOe),
  .irq    (irq)
);

// File: tb/gpio_port_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut, pinOe;
  logic        irq;
  int          total = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] rd;
    logic [7:0]  oe;
    logic [7:0]  out;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF, 8'h00, 8'h00}, // R2 mode
    '{8'h10, 32'h0000_000F, 8'h10, 32'h0000_000F, 8'h0F, 8'h00}, // R2 R5 dir
    '{8'h20, 32'h0000_003C, 8'h20, 32'h0000_003C, 8'h0F, 8'h3C}, // R2 R5 drive
    '{8'hA0, 32'h0000_F0AA, 8'h20, 32'h0000_00AC, 8'h0F, 8'hAC}, // R3 masked drive
    '{8'hA0, 32'h0000_00FF, 8'hA0, 32'h0000_00AC, 8'h0F, 8'hAC}, // R3 empty mask
    '{8'h80, 32'h0000_0300, 8'h00, 32'h0000_00FC, 8'h0C, 8'hAC}, // R3 R5 masked mode
    '{8'h90, 32'h0000_F0F0, 8'h10, 32'h0000_00FF, 8'hFC, 8'hAC}, // R3 R5 masked dir
    '{8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000, 8'hFC, 8'hAC}, // R2 sample ignores write
    '{8'h70, 32'h0000_0000, 8'h70, 32'h0000_0000, 8'hFC, 8'hAC}, // R2 ack reads zero
    '{8'h60, 32'hFF12_3456, 8'h60, 32'h0012_3456, 8'hFC, 8'hAC}, // R2 trigger 24 bits
    '{8'hE0, 32'h0000_0F00, 8'h60, 32'h0012_3450, 8'hFC, 8'hAC}, // R4 masked trigger
    '{8'h50, 32'h0000_01FF, 8'h50, 32'h0000_00FF, 8'hFC, 8'hAC}, // R2 enable
    '{8'h50, 32'h0000_0000, 8'h50, 32'h0000_0000, 8'hFC, 8'hAC}  // R2 enable off
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    rdEn = 1'b0;
  endtask

  task automatic setPins(input logic [7:0] v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pinOe", {24'h0, pinOe}, 32'h0);
    chk("R1 pinOut", {24'h0, pinOut}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    rd(8'h00, got); chk("R1 mode", got, 32'h0);
    rd(8'h60, got); chk("R1 trigger", got, 32'h0);
    rd(8'h50, got); chk("R1 enable", got, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, got);
      chk($sformatf("R2/R3 vector %0d rdData", i), got, VECS[i].rd);
      chk($sformatf("R5 vector %0d pinOe", i), {24'h0, pinOe}, {24'h0, VECS[i].oe});
      chk($sformatf("R5 vector %0d pinOut", i), {24'h0, pinOut}, {24'h0, VECS[i].out});
    end

    // R2 unaligned, missing alias, and idle reads
    rd(8'h08, got); chk("R2 unaligned read", got, 32'h0);
    rd(8'hB0, got); chk("R2 no sample alias", got, 32'h0);
    @(negedge clk); addr = 8'h20; #1 chk("R2 rdEn low", rdData, 32'h0);

    // pin0 rising, pin1 falling, pin2 both, pin3 level high, pin4 level low, 5-7 rising
    wr(8'h60, 32'h0004_E7E9);
    wr(8'h70, 32'h0000_00FF);
    rd(8'h40, got); chk("R8 level-low active after clear", got, 32'h10);

    setPins(8'h0F);
    rd(8'h40, got); chk("R7 rise/both/level-high", got, 32'h1D);
    chk("R10 irq masked", {31'h0, irq}, 32'h0);

    setPins(8'h00);
    rd(8'h40, got); chk("R7 fall sticky edges", got, 32'h17);

    wr(8'h70, 32'h0000_0002);
    rd(8'h40, got); chk("R9 ack clears one", got, 32'h15);
    wr(8'h70, 32'h0000_0000);
    rd(8'h40, got); chk("R9 ack zero no effect", got, 32'h15);
    wr(8'h70, 32'h0000_0010);
    rd(8'h40, got); chk("R8 level survives ack", got, 32'h15);

    setPins(8'h10);
    rd(8'h40, got); chk("R8 level drops", got, 32'h05);
    rd(8'h30, got); chk("R6 sample value", got, 32'h10);

    wr(8'h50, 32'h0000_0008);
    chk("R10 enabled bit not pending", {31'h0, irq}, 32'h0);
    wr(8'hD0, 32'h0000_0101);
    rd(8'h50, got); chk("R3 masked enable", got, 32'h09);
    chk("R10 irq raised", {31'h0, irq}, 32'h1);
    wr(8'h70, 32'h0000_0001);
    chk("R10 irq after ack", {31'h0, irq}, 32'h0);
    wr(8'hC0, 32'h0000_8080);
    rd(8'h40, got); chk("R9 masked status load", got, 32'h84);

    // R6 two-flop latency
    @(negedge clk); pinIn = 8'hA5;
    rd(8'h30, got); chk("R6 one edge old value", got, 32'h10);
    rd(8'h30, got); chk("R6 two edges new value", got, 32'hA5);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1 pinOe after reset", {24'h0, pinOe}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    rd(8'h20, got); chk("R1 drive after reset", got, 32'h0);

    finishRun();
  end
endmodule